// File: doc/BRIEF.md
# First-Ready SDRAM Command Scheduler

This block sits between a set of stream request sources and a single multi-bank SDRAM device. Read and write references enter a small pending pool. Each cycle the block looks at every pending reference and works out which DRAM command that reference needs next. A reference that targets the open row of its bank needs a column command. A reference that targets a different row of an open bank needs a precharge. A reference that targets a closed bank needs an activate. Of the references whose next command is legal in this cycle, the oldest one wins the shared command bus.

The block ignores which stream produced a reference. Indirect (gather/scatter) references are therefore reordered exactly like strided ones. A reference that is waiting on a bank timer never stalls a younger reference that could issue. The goal is sustained DRAM throughput, not the lowest latency for any single reference.

Each bank keeps its open row and a countdown for the activate-to-column delay and the precharge-to-activate delay. Read data comes back on the response port a fixed read latency after the read command, tagged with the tag of the request. A write is acknowledged, with its tag, in the cycle its column command goes out.

Top module: `frdram_sched`

## Requirements
- R1: After reset the block issues no command, asserts no response and no write acknowledge, and shows request ready high.
- R2: `req_ready_o` is low exactly when 8 references are pending. A reference leaves the pool in the cycle its column command is issued, and a request is taken only on a cycle where valid and ready are both high.
- R3: A reference to the row already open in its bank is served by a column command alone. Several such references after one activate cause no further activate and no precharge.
- R4: A reference to another row of an open bank causes one precharge of that bank and then one activate of the new row before its column command. A precharge is only ever issued to an open bank.
- R5: Command codes are 0 for precharge, 1 for activate, 2 for read and 3 for write, with at most one command per cycle. An activate goes only to a closed bank, at least T_RP cycles after that bank's precharge. A read or write goes only to the open row, at least T_RCD cycles after the activate.
- R6: Each cycle the oldest pending reference whose next command is legal is chosen, so a younger reference that is ready issues ahead of an older one that is waiting on a bank timer.
- R7: A read response appears exactly T_CL cycles after its read command, carrying the request's tag and the data the device returns for that row and column.
- R8: A write acknowledge with the request's tag is asserted in the cycle the write command is issued. That write command carries the request's bank, row, column and data, and a later read of the same location returns that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Pool has a free slot |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_wdata_i | input | DATA_W | Write data |
| req_tag_i | input | TAG_W | Request tag |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_code_o | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| cmd_col_o | output | COL_W | Command column |
| cmd_wdata_o | output | DATA_W | Data for a write command |
| dram_rdata_i | input | DATA_W | Device read data, valid T_CL cycles after a read command |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_tag_o | output | TAG_W | Tag of the read response |
| rsp_data_o | output | DATA_W | Read response data |
| wack_valid_o | output | 1 | Write acknowledge |
| wack_tag_o | output | TAG_W | Tag of the acknowledged write |

## Verification
The bench builds the block with its default parameters: four banks, an eight-entry pool, 3-cycle activate, precharge and read delays, and 4-bit tags. With these values eleven references can be in flight at once (eight pending and three in the read pipe) without any tag being reused. Random traffic is kept to four rows per bank, so row hits, row conflicts and bank-parallel activates all occur often. Directed runs to a single bank fill the pool quickly, because every reference in them needs a precharge and an activate.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {BK_IDLE, BK_OPENING, BK_OPEN, BK_CLOSING} bank_st_e;
  typedef enum logic [1:0] {CMD_PRE = 2'd0, CMD_ACT = 2'd1, CMD_RD = 2'd2, CMD_WR = 2'd3} cmd_e;
endpackage

// File: rtl/frs_bank.sv
module frs_bank import frs_pkg::*; #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             idle_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_W = $clog2(TMAX + 1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             bank_en;

  // Column legal once the activate countdown has expired; activate legal once the precharge countdown has.
  assign open_o = (st_q == BK_OPEN) || (st_q == BK_OPENING && cnt_q == '0);
  assign idle_o = (st_q == BK_IDLE) || (st_q == BK_CLOSING && cnt_q == '0);
  assign row_o  = row_q;
  assign bank_en = act_i || pre_i || (st_q == BK_OPENING) || (st_q == BK_CLOSING);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    row_d = row_q;
    case (st_q)
      BK_OPENING: if (cnt_q == '0) st_d = BK_OPEN;
                  else cnt_d = cnt_q - 1'b1;
      BK_CLOSING: if (cnt_q == '0) st_d = BK_IDLE;
                  else cnt_d = cnt_q - 1'b1;
      default: ;
    endcase
    if (act_i) begin
      st_d  = BK_OPENING;
      cnt_d = CNT_W'(T_RCD - 1);
      row_d = row_i;
    end
    if (pre_i) begin
      st_d  = BK_CLOSING;
      cnt_d = CNT_W'(T_RP - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (bank_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act_i) row_q <= row_d;
  end

  assert_act_closed_R5: assert property (@(posedge clk) disable iff (!rst_n) act_i |-> idle_o);
  assert_col_open_R5:   assert property (@(posedge clk) disable iff (!rst_n) col_i |-> open_o);
  assert_pre_open_R4:   assert property (@(posedge clk) disable iff (!rst_n) pre_i |-> open_o);
  assert_one_cmd_R5:    assert property (@(posedge clk) disable iff (!rst_n) $countones({act_i, pre_i, col_i}) <= 1);
endmodule

// File: rtl/frs_queue.sv
module frs_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              pop_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  output logic              full_o,
  output logic              vld_o  [DEPTH],
  output logic              wr_o   [DEPTH],
  output logic [BANK_W-1:0] bank_o [DEPTH],
  output logic [ROW_W-1:0]  row_o  [DEPTH],
  output logic [COL_W-1:0]  col_o  [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH],
  output logic [TAG_W-1:0]  tag_o  [DEPTH],
  output logic [IDX_W-1:0]  age_o  [DEPTH]
);
  logic              vld_q [DEPTH];
  logic              vld_d [DEPTH];
  logic [IDX_W-1:0]  age_q [DEPTH];
  logic [IDX_W-1:0]  age_d [DEPTH];
  logic              wr_q  [DEPTH];
  logic [BANK_W-1:0] bank_q[DEPTH];
  logic [ROW_W-1:0]  row_q [DEPTH];
  logic [COL_W-1:0]  col_q [DEPTH];
  logic [DATA_W-1:0] data_q[DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [IDX_W-1:0]  free_idx;

  always_comb begin
    free_idx = '0;
    full_o   = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IDX_W'(i);
        full_o   = 1'b0;
      end
    end
  end

  // Age counts the younger live entries: unique, and bounded by DEPTH-1.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i];
      age_d[i] = age_q[i];
      if (vld_q[i])
        age_d[i] = age_q[i] + IDX_W'(push_i)
                 - IDX_W'(pop_i && (age_q[i] > age_q[pop_idx_i]));
      if (pop_i && pop_idx_i == IDX_W'(i)) vld_d[i] = 1'b0;
      if (push_i && free_idx == IDX_W'(i)) begin
        vld_d[i] = 1'b1;
        age_d[i] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= 1'b0;
        age_q[i] <= '0;
      end
    end else if (push_i || pop_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= vld_d[i];
        age_q[i] <= age_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      wr_q[free_idx]   <= wr_i;
      bank_q[free_idx] <= bank_i;
      row_q[free_idx]  <= row_i;
      col_q[free_idx]  <= col_i;
      data_q[free_idx] <= data_i;
      tag_q[free_idx]  <= tag_i;
    end
  end

  assign vld_o  = vld_q;
  assign wr_o   = wr_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign data_o = data_q;
  assign tag_o  = tag_q;
  assign age_o  = age_q;

  assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !full_o);
  assert_pop_live_R6:  assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> vld_q[pop_idx_i]);
endmodule

// File: rtl/frs_rdpipe.sv
module frs_rdpipe #(
  parameter int LAT   = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_v,
  output logic [TAG_W-1:0] out_tag
);
  logic             v_q [LAT];
  logic [TAG_W-1:0] t_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) v_q[s] <= 1'b0;
    end else begin
      v_q[0] <= in_v;
      for (int s = 1; s < LAT; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) t_q[0] <= in_tag;
    for (int s = 1; s < LAT; s++)
      if (v_q[s-1]) t_q[s] <= t_q[s-1];
  end

  assign out_v   = v_q[LAT-1];
  assign out_tag = t_q[LAT-1];
endmodule

// File: rtl/frdram_sched.sv
module frdram_sched import frs_pkg::*; #(
  parameter int N_BANK  = 4,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int Q_DEPTH = 8,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_CL    = 3,
  localparam int BANK_W = $clog2(N_BANK),
  localparam int IDX_W  = $clog2(Q_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_code_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              wack_valid_o,
  output logic [TAG_W-1:0]  wack_tag_o
);
  logic              q_full;
  logic              q_vld  [Q_DEPTH];
  logic              q_wr   [Q_DEPTH];
  logic [BANK_W-1:0] q_bank [Q_DEPTH];
  logic [ROW_W-1:0]  q_row  [Q_DEPTH];
  logic [COL_W-1:0]  q_col  [Q_DEPTH];
  logic [DATA_W-1:0] q_data [Q_DEPTH];
  logic [TAG_W-1:0]  q_tag  [Q_DEPTH];
  logic [IDX_W-1:0]  q_age  [Q_DEPTH];

  logic              bk_open [N_BANK];
  logic              bk_idle [N_BANK];
  logic [ROW_W-1:0]  bk_row  [N_BANK];

  logic              found, is_col, push;
  logic [IDX_W-1:0]  sel_idx, best_age;
  cmd_e              sel_kind;
  logic [BANK_W-1:0] eb, sel_bank;

  assign req_ready_o = !q_full;
  assign push        = req_valid_i && req_ready_o;

  frs_queue #(.DEPTH(Q_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
              .DATA_W(DATA_W), .TAG_W(TAG_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_i(push), .wr_i(req_write_i), .bank_i(req_bank_i),
    .row_i(req_row_i), .col_i(req_col_i), .data_i(req_wdata_i), .tag_i(req_tag_i),
    .pop_i(is_col), .pop_idx_i(sel_idx), .full_o(q_full), .vld_o(q_vld), .wr_o(q_wr),
    .bank_o(q_bank), .row_o(q_row), .col_o(q_col), .data_o(q_data), .tag_o(q_tag),
    .age_o(q_age));

  // First-ready pick: the oldest entry whose next command is legal now, whatever its stream.
  always_comb begin
    found    = 1'b0;
    sel_idx  = '0;
    best_age = '0;
    sel_kind = CMD_PRE;
    eb       = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      eb = q_bank[i];
      if (q_vld[i] && (bk_open[eb] || bk_idle[eb]) && (!found || q_age[i] > best_age)) begin
        found    = 1'b1;
        sel_idx  = IDX_W'(i);
        best_age = q_age[i];
        if (bk_open[eb])
          sel_kind = (bk_row[eb] == q_row[i]) ? (q_wr[i] ? CMD_WR : CMD_RD) : CMD_PRE;
        else
          sel_kind = CMD_ACT;
      end
    end
  end

  assign sel_bank    = q_bank[sel_idx];
  assign is_col      = found && (sel_kind == CMD_RD || sel_kind == CMD_WR);
  assign cmd_valid_o = found;
  assign cmd_code_o  = sel_kind;
  assign cmd_bank_o  = sel_bank;
  assign cmd_row_o   = q_row[sel_idx];
  assign cmd_col_o   = q_col[sel_idx];
  assign cmd_wdata_o = q_data[sel_idx];

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    frs_bank #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(found && sel_kind == CMD_ACT && sel_bank == BANK_W'(g)),
      .pre_i(found && sel_kind == CMD_PRE && sel_bank == BANK_W'(g)),
      .col_i(is_col && sel_bank == BANK_W'(g)),
      .row_i(q_row[sel_idx]),
      .open_o(bk_open[g]), .idle_o(bk_idle[g]), .row_o(bk_row[g]));
  end

  frs_rdpipe #(.LAT(T_CL), .TAG_W(TAG_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .in_v(found && sel_kind == CMD_RD), .in_tag(q_tag[sel_idx]),
    .out_v(rsp_valid_o), .out_tag(rsp_tag_o));

  assign rsp_data_o   = dram_rdata_i;
  assign wack_valid_o = found && sel_kind == CMD_WR;
  assign wack_tag_o   = q_tag[sel_idx];
endmodule

// File: tb/frdram_sched_tb_top.sv
module frdram_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, RW = 12, CW = 8, DW = 32, TW = 4, QD = 8;
  localparam int T_RCD = 3, T_RP = 3, T_CL = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid, req_ready, req_write;
  logic [1:0]    req_bank;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic [DW-1:0] req_wdata;
  logic [TW-1:0] req_tag;
  logic          cmd_valid;
  logic [1:0]    cmd_code, cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [DW-1:0] cmd_wdata, rsp_data;
  logic [DW-1:0] dram_rdata = '0;
  logic          rsp_valid, wack_valid;
  logic [TW-1:0] rsp_tag, wack_tag;

  frdram_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_wdata_i(req_wdata), .req_tag_i(req_tag), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code),
    .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col), .cmd_wdata_o(cmd_wdata),
    .dram_rdata_i(dram_rdata), .rsp_valid_o(rsp_valid), .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data),
    .wack_valid_o(wack_valid), .wack_tag_o(wack_tag));

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] pattern(input int b, input int r, input int c);
    return 32'h5A00_0000 ^ (b << 20) ^ (r << 10) ^ (c * 32'h0001_0101);
  endfunction

  // Device model and bookkeeping
  logic [31:0] mem [4][8][16];
  logic [31:0] t_data [16];
  bit          t_wr [16], t_busy [16];
  int          t_b [16], t_r [16], t_c [16];
  int          rf_cyc [64];
  logic [31:0] rf_data [64];
  int          rf_h = 0, rf_t = 0;
  bit          m_open [4];
  int          m_row [4], m_act [4], m_pre [4], n_act [4], n_pre [4];
  int          n_acc = 0, n_col = 0, n_rsp = 0, next_tag = 0;
  int          rsp_log [1024];
  bit          saw_full = 0;
  int          mb, mr, mc, mt;
  bit          due;

  always @(negedge clk) begin
    if (rst_n) begin
      due = (rf_h != rf_t) && (rf_cyc[rf_h % 64] + T_CL == cyc);
      dram_rdata = due ? rf_data[rf_h % 64] : '0;
      #1;
      // R2: ready low exactly when the pool holds QD references
      chk(req_ready == ((n_acc - n_col) < QD), "R2", "ready vs pending", req_ready, (n_acc - n_col) < QD);
      if (!req_ready) saw_full = 1;
      // R7: response timing, tag and data
      if (rsp_valid || due)
        chk(rsp_valid && due, "R7", "response T_CL after read", rsp_valid, due);
      if (rsp_valid) begin
        mt = int'(rsp_tag);
        chk(t_busy[mt] && !t_wr[mt] && rsp_data == t_data[mt], "R7", "response data for tag",
            rsp_data, t_data[mt]);
        t_busy[mt] = 0;
        rsp_log[n_rsp % 1024] = mt;
        n_rsp++;
      end
      if (due) rf_h++;
      if (cmd_valid) begin
        mb = int'(cmd_bank); mr = int'(cmd_row[2:0]); mc = int'(cmd_col[3:0]);
        case (cmd_code)
          2'd0: begin
            chk(m_open[mb], "R4", "precharge to open bank", m_open[mb], 1);
            m_open[mb] = 0; m_pre[mb] = cyc; n_pre[mb]++;
          end
          2'd1: begin
            chk(!m_open[mb] && (cyc - m_pre[mb]) >= T_RP, "R5", "activate after T_RP",
                cyc - m_pre[mb], T_RP);
            m_open[mb] = 1; m_row[mb] = int'(cmd_row); m_act[mb] = cyc; n_act[mb]++;
          end
          default: begin
            chk(m_open[mb] && m_row[mb] == int'(cmd_row) && (cyc - m_act[mb]) >= T_RCD, "R5",
                "column after T_RCD to open row", cyc - m_act[mb], T_RCD);
            n_col++;
            if (cmd_code == 2'd2) begin
              rf_cyc[rf_t % 64] = cyc; rf_data[rf_t % 64] = mem[mb][mr][mc]; rf_t++;
            end else begin
              mt = int'(wack_tag);
              chk(wack_valid && t_busy[mt] && t_wr[mt] && t_b[mt] == mb && t_r[mt] == int'(cmd_row)
                  && t_c[mt] == int'(cmd_col) && t_data[mt] == cmd_wdata, "R8", "write command and ack",
                  cmd_wdata, t_data[mt]);
              mem[mb][mr][mc] = cmd_wdata;
              t_busy[mt] = 0;
            end
          end
        endcase
      end
      if (wack_valid && !(cmd_valid && cmd_code == 2'd3))
        chk(0, "R8", "ack without write command", wack_valid, 0);
    end
  end

  task automatic push(input bit wr, input int b, input int r, input int c, input logic [31:0] d,
                      output int tag);
    tag = next_tag;
    next_tag = (next_tag + 1) % 16;
    t_busy[tag] = 1; t_wr[tag] = wr; t_b[tag] = b; t_r[tag] = r; t_c[tag] = c; t_data[tag] = d;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = 2'(b); req_row = RW'(r); req_col = CW'(c);
    req_wdata = d; req_tag = TW'(tag);
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    n_acc++;
    #1 req_valid = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((n_acc != n_col || rf_h != rf_t) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int tg, tx, ty, a0, p0, b, r, c;
    bit wr;
    void'($urandom(32'd20011));
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 16; k++) mem[i][j][k] = pattern(i, j, k);
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_act[i] = -1000; m_pre[i] = -1000; n_act[i] = 0; n_pre[i] = 0;
    end
    for (int i = 0; i < 16; i++) t_busy[i] = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_bank = 0; req_row = 0; req_col = 0;
    req_wdata = 0; req_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk); #3;
    // R1: quiet after reset
    chk(!cmd_valid, "R1", "no command", cmd_valid, 0);
    chk(req_ready, "R1", "ready high", req_ready, 1);
    chk(!rsp_valid && !wack_valid, "R1", "no response/ack", {rsp_valid, wack_valid}, 0);

    // R3: four hits to one row after a single activate
    a0 = n_act[2]; p0 = n_pre[2];
    for (int k = 0; k < 4; k++) push(0, 2, 1, k, pattern(2, 1, k), tg);
    drain();
    chk(n_act[2] - a0 == 1, "R3", "activates for row hits", n_act[2] - a0, 1);
    chk(n_pre[2] - p0 == 0, "R3", "precharges for row hits", n_pre[2] - p0, 0);

    // R4: conflicting row in the open bank
    a0 = n_act[2]; p0 = n_pre[2];
    push(0, 2, 2, 5, pattern(2, 2, 5), tg);
    drain();
    chk(n_pre[2] - p0 == 1, "R4", "precharge on conflict", n_pre[2] - p0, 1);
    chk(n_act[2] - a0 == 1, "R4", "activate on conflict", n_act[2] - a0, 1);

    // R6: older reference waiting on T_RCD must not hold back a younger hit
    push(0, 1, 3, 2, pattern(1, 3, 2), tg);
    drain();
    push(0, 0, 0, 1, pattern(0, 0, 1), tx);
    push(0, 1, 3, 2, pattern(1, 3, 2), ty);
    drain();
    chk(rsp_log[(n_rsp - 2) % 1024] == ty, "R6", "younger ready hit first", rsp_log[(n_rsp - 2) % 1024], ty);
    chk(rsp_log[(n_rsp - 1) % 1024] == tx, "R6", "older blocked one second", rsp_log[(n_rsp - 1) % 1024], tx);

    // R2: conflicting rows in one bank fill the pool
    saw_full = 0;
    for (int k = 0; k < 12; k++) push(0, 3, k % 8, 0, pattern(3, k % 8, 0), tg);
    chk(saw_full, "R2", "ready went low when full", saw_full, 1);
    drain();

    // R5, R7, R8: constrained random mix
    for (int n = 0; n < 250; n++) begin
      wr = ($urandom % 3) == 0;
      b = $urandom % 4; r = $urandom % 4;
      if (wr) begin
        c = 8 + $urandom % 8;
        push(1, b, r, c, $urandom, tg);
      end else begin
        c = $urandom % 8;
        push(0, b, r, c, pattern(b, r, c), tg);
      end
      if (($urandom % 4) == 0) @(negedge clk);
    end
    drain();

    // R8: write then read back
    for (int k = 0; k < 4; k++) push(1, k, 6, 9, 32'hC0DE_0000 + k, tg);
    drain();
    for (int k = 0; k < 4; k++) push(0, k, 6, 9, 32'hC0DE_0000 + k, tg);
    drain();
    chk(n_acc == n_col, "R8", "all references completed", n_col, n_acc);
    finish_run();
  end
endmodule